// File: doc/BRIEF.md
# Escalating Watchdog Recovery Controller

This supervisor watches a windowed heartbeat and four fault inputs (bus/driver stall, thermal protection, power protection and a manual request). It turns repeated trouble into a graded series of recovery actions. The first failure gets the least disruptive action, a service restart. If trouble returns before the previous action has proven itself, the next action is stronger: module reset, then warm reset of the processor, then cold board reset, and finally a sticky degraded safe mode.

Before any action the controller records a cause code and the chosen stage, and raises a snapshot request so that an evidence collector can capture rails, temperatures and link counters. After the collector acknowledges, a programmable flush delay runs before the stage pulse, so logs can reach storage.

A sliding time window counts recent reset actions. Each prior action in the window lengthens the pre-reset delay by a programmable backoff step. Once the window already holds the configured limit of actions, the next failure goes straight to safe mode. Safe mode ends only on an explicit clear, which also empties the window.

Top module: `rl_supervisor`

## Requirements
- R1: Every recovery action is one single-cycle pulse on exactly one bit of `act_o`. The bit positions are: 0 service restart, 1 module reset, 2 warm reset, 3 cold reset, 4 safe-mode entry. The set bit always matches `stage_o`, which uses the codes 0 to 4 in the same order.
- R2: The heartbeat counter restarts on reset, on each kick, on each fault and on each stage pulse.
  - A kick is valid when at least `cfg_win_min_i` cycles have passed since the last restart.
  - A kick that comes earlier is a fault.
  - Going more than `cfg_win_max_i` cycles without a kick is a fault.
  - Both faults report cause code 1.
- R3: The cause code is picked by fixed priority when several triggers coincide: manual 5, power 4, thermal 3, stall 2, heartbeat 1. The code 0 means no event has been recorded.
- R4: When a trigger is accepted, `snap_req_o` rises with `cause_o` and `stage_o` already holding the new record. It stays high, with no stage pulse, until `snap_ack_i` is sampled.
- R5: The stage pulse appears exactly `cfg_flush_i + cfg_backoff_i * fail_cnt_o + 1` cycles after the clock edge that samples the acknowledge.
- R6: A trigger during a stage's recovery interval (`cfg_recover_i` cycles after the pulse) escalates to the next stage. A trigger after a cold reset goes to safe mode, and safe-mode entry pulses bit 4 and raises `safe_o`.
- R7: A recovery interval that passes with no trigger returns the ladder to stage 0 for the next trigger. `fail_cnt_o` keeps its windowed count.
- R8: `fail_cnt_o` counts the stage 0 to 3 pulses issued within the last `cfg_loop_win_i` cycles. Each pulse leaves the count once it is older than the window.
- R9: A trigger arriving while `fail_cnt_o` equals `LOOP_N` selects safe mode directly, regardless of ladder position.
- R10: In safe mode, triggers and heartbeat faults are ignored: no snapshot request and no pulse. `safe_o` stays high until `clear_i`.
- R11: `clear_i` in safe mode leaves safe mode and sets `fail_cnt_o` to 0, and the next trigger uses stage 0. Outside safe mode, `clear_i` has no effect.
- R12: After reset, all pulses, `snap_req_o`, `safe_o`, `cause_o`, `stage_o` and `fail_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hb_kick_i | input | 1 | Heartbeat kick, one cycle per kick |
| stall_i | input | 1 | Bus or driver stall indication |
| thermal_i | input | 1 | Thermal protection event |
| power_i | input | 1 | Power protection event |
| manual_i | input | 1 | Manual recovery request |
| clear_i | input | 1 | Leave safe mode and empty the window |
| snap_ack_i | input | 1 | Evidence snapshot taken |
| cfg_win_min_i | input | TW | Earliest valid kick, in cycles |
| cfg_win_max_i | input | TW | Latest valid kick, in cycles |
| cfg_recover_i | input | TW | Recovery interval per stage |
| cfg_flush_i | input | TW | Base delay from acknowledge to pulse |
| cfg_backoff_i | input | TW | Extra delay per windowed action |
| cfg_loop_win_i | input | TSW | Sliding window length, in cycles |
| act_o | output | 5 | One pulse bit per recovery stage |
| snap_req_o | output | 1 | Evidence snapshot request |
| safe_o | output | 1 | Safe mode active |
| cause_o | output | 3 | Last recorded cause code |
| stage_o | output | 3 | Last recorded stage code |
| fail_cnt_o | output | CW | Actions inside the sliding window |

## Verification
A wrong ladder position shows at the very next snapshot request as an unexpected `stage_o`, and at the pulse as the wrong `act_o` bit. A stale or leaked window entry shows directly on `fail_cnt_o`. It also appears one action later as a pulse delay that is off by a multiple of the backoff step, or as an early or missing safe-mode entry. Heartbeat window errors appear within one window length as a snapshot request that comes too soon, comes too late or never comes.

// File: rtl/rl_pkg.sv
package rl_pkg;

   localparam int unsigned NUM_STAGES = 5;

   typedef enum logic [2:0] {
      CAUSE_NONE   = 3'd0,
      CAUSE_WDOG   = 3'd1,
      CAUSE_STALL  = 3'd2,
      CAUSE_THERM  = 3'd3,
      CAUSE_POWER  = 3'd4,
      CAUSE_MANUAL = 3'd5
   } cause_e;

   // ladder order is behaviour: each escalation moves one step down
   typedef enum logic [2:0] {
      STG_SVC  = 3'd0,
      STG_MOD  = 3'd1,
      STG_WARM = 3'd2,
      STG_COLD = 3'd3,
      STG_SAFE = 3'd4
   } stage_e;

   typedef enum logic [2:0] {
      ST_WATCH = 3'd0,
      ST_SNAP  = 3'd1,
      ST_HOLD  = 3'd2,
      ST_RECOV = 3'd3,
      ST_SAFE  = 3'd4
   } ladder_st_e;

   function automatic cause_e pick_cause(input logic manual, input logic power,
                                         input logic thermal, input logic stall,
                                         input logic wdog);
      cause_e c;
      if (manual)       c = CAUSE_MANUAL;
      else if (power)   c = CAUSE_POWER;
      else if (thermal) c = CAUSE_THERM;
      else if (stall)   c = CAUSE_STALL;
      else if (wdog)    c = CAUSE_WDOG;
      else              c = CAUSE_NONE;
      return c;
   endfunction

endpackage

// File: rtl/rl_hb_window.sv
module rl_hb_window #(
   parameter int unsigned TW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          restart_i,
   input  logic          kick_i,
   input  logic [TW-1:0] win_min_i,
   input  logic [TW-1:0] win_max_i,
   output logic          fault_o
);

   if (TW < 2) begin : g_bad_tw
      $error("rl_hb_window: TW must be at least 2");
   end

   logic [TW-1:0] cnt_q;
   logic          early;
   logic          late;

   always_comb begin
      early = en_i && !restart_i && kick_i && (cnt_q < win_min_i);
      late  = en_i && !restart_i && !kick_i && (cnt_q >= win_max_i);
   end

   assign fault_o = early | late;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!en_i || restart_i || kick_i || late) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // counter never runs past the late limit without reporting it
   assert_cnt_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= win_max_i);

   // a reported fault always restarts the window
   assert_fault_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |=> (cnt_q == '0));

endmodule

// File: rtl/rl_loop_guard.sv
module rl_loop_guard #(
   parameter int unsigned SLOTS = 3,
   parameter int unsigned TSW   = 20,
   parameter int unsigned CW    = $clog2(SLOTS + 1)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           clear_i,
   input  logic           record_i,
   input  logic [TSW-1:0] win_i,
   output logic [CW-1:0]  count_o,
   output logic           full_o
);

   if (SLOTS < 1) begin : g_bad_slots
      $error("rl_loop_guard: SLOTS must be at least 1");
   end
   if (TSW < 4) begin : g_bad_tsw
      $error("rl_loop_guard: TSW must be at least 4");
   end
   if (CW < $clog2(SLOTS + 1)) begin : g_bad_cw
      $error("rl_loop_guard: CW too narrow for SLOTS");
   end

   logic [TSW-1:0]   now_q;
   logic [SLOTS-1:0] vld;
   logic [SLOTS-1:0] wr_sel;
   logic             found;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) now_q <= '0;
      else         now_q <= now_q + 1'b1;
   end

   // first free slot takes the new timestamp
   always_comb begin
      wr_sel = '0;
      found  = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (!found && !vld[i]) begin
            wr_sel[i] = record_i;
            found     = 1'b1;
         end
      end
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic           v_q;
      logic [TSW-1:0] ts_q;
      logic [TSW-1:0] age;
      logic           expire;

      assign age    = now_q - ts_q;
      assign expire = v_q && (age >= win_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            v_q  <= 1'b0;
            ts_q <= '0;
         end else if (clear_i) begin
            v_q <= 1'b0;
         end else if (wr_sel[g]) begin
            v_q  <= 1'b1;
            ts_q <= now_q;
         end else if (expire) begin
            v_q <= 1'b0;
         end
      end

      assign vld[g] = v_q;
   end

   always_comb begin
      count_o = '0;
      for (int i = 0; i < SLOTS; i++) begin
         count_o = count_o + CW'(vld[i]);
      end
   end

   assign full_o = (count_o >= CW'(SLOTS));

   // the ladder must divert to safe mode instead of logging into a full window
   assert_no_record_when_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      record_i |-> !full_o);

   assert_count_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o <= CW'(SLOTS));

   assert_clear_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (count_o == '0));

endmodule

// File: rtl/rl_ladder_fsm.sv
module rl_ladder_fsm
   import rl_pkg::*;
#(
   parameter int unsigned TW = 16,
   parameter int unsigned CW = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  trig_i,
   input  cause_e                cause_i,
   input  logic                  guard_full_i,
   input  logic [CW-1:0]         fail_cnt_i,
   input  logic                  snap_ack_i,
   input  logic                  clear_i,
   input  logic [TW-1:0]         cfg_recover_i,
   input  logic [TW-1:0]         cfg_flush_i,
   input  logic [TW-1:0]         cfg_backoff_i,
   output logic [NUM_STAGES-1:0] act_o,
   output logic                  snap_req_o,
   output logic                  safe_o,
   output logic                  mon_en_o,
   output logic                  hb_restart_o,
   output logic                  record_o,
   output logic                  guard_clear_o,
   output cause_e                cause_o,
   output stage_e                stage_o
);

   localparam int unsigned HW    = TW + CW + 1;
   localparam int unsigned ACT_W = NUM_STAGES;

   if (TW < 2) begin : g_bad_tw
      $error("rl_ladder_fsm: TW must be at least 2");
   end

   ladder_st_e       st_q;
   stage_e           stage_q;
   stage_e           esc_stage;
   cause_e           cause_q;
   logic [HW-1:0]    timer_q;
   logic [HW-1:0]    hold_tgt;
   logic [ACT_W-1:0] act_q;
   logic             fire;
   logic             leave_safe;

   always_comb begin
      hold_tgt   = HW'(cfg_flush_i) + HW'(cfg_backoff_i) * HW'(fail_cnt_i);
      fire       = (st_q == ST_HOLD) && (timer_q >= hold_tgt);
      leave_safe = (st_q == ST_SAFE) && clear_i;
      if (guard_full_i || stage_q == STG_COLD || stage_q == STG_SAFE) begin
         esc_stage = STG_SAFE;
      end else begin
         esc_stage = stage_e'(stage_q + 3'd1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_WATCH;
         stage_q <= STG_SVC;
         cause_q <= CAUSE_NONE;
         timer_q <= '0;
         act_q   <= '0;
      end else begin
         act_q <= '0;
         unique case (st_q)
            ST_WATCH: begin
               if (trig_i) begin
                  cause_q <= cause_i;
                  stage_q <= guard_full_i ? STG_SAFE : STG_SVC;
                  st_q    <= ST_SNAP;
               end
            end
            ST_SNAP: begin
               if (snap_ack_i) begin
                  timer_q <= '0;
                  st_q    <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (fire) begin
                  act_q   <= ACT_W'(1) << stage_q;
                  timer_q <= '0;
                  st_q    <= (stage_q == STG_SAFE) ? ST_SAFE : ST_RECOV;
               end else begin
                  timer_q <= timer_q + 1'b1;
               end
            end
            ST_RECOV: begin
               if (trig_i) begin
                  cause_q <= cause_i;
                  stage_q <= esc_stage;
                  st_q    <= ST_SNAP;
               end else if (timer_q >= HW'(cfg_recover_i)) begin
                  st_q <= ST_WATCH;
               end else begin
                  timer_q <= timer_q + 1'b1;
               end
            end
            ST_SAFE: begin
               if (clear_i) st_q <= ST_WATCH;
            end
            default: st_q <= ST_WATCH;
         endcase
      end
   end

   assign act_o         = act_q;
   assign snap_req_o    = (st_q == ST_SNAP);
   assign safe_o        = (st_q == ST_SAFE);
   assign mon_en_o      = (st_q != ST_SAFE);
   assign record_o      = fire && (stage_q != STG_SAFE);
   assign hb_restart_o  = fire | leave_safe;
   assign guard_clear_o = leave_safe;
   assign cause_o       = cause_q;
   assign stage_o       = stage_q;

   assert_one_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(act_o));

   assert_pulse_matches_stage_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_o != '0) |-> (act_o == (ACT_W'(1) << stage_o)));

   assert_quiet_during_snapshot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snap_req_o |-> (act_o == '0));

   assert_flush_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(snap_req_o) |-> (act_o == '0));

   assert_safe_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_o[STG_SAFE] |-> safe_o);

   assert_safe_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (safe_o && !clear_i) |=> safe_o);

   assert_safe_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      safe_o |-> !snap_req_o);

endmodule

// File: rtl/rl_supervisor.sv
module rl_supervisor
   import rl_pkg::*;
#(
   parameter int unsigned TW     = 16,
   parameter int unsigned TSW    = 20,
   parameter int unsigned LOOP_N = 3,
   localparam int unsigned CW    = $clog2(LOOP_N + 1)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  hb_kick_i,
   input  logic                  stall_i,
   input  logic                  thermal_i,
   input  logic                  power_i,
   input  logic                  manual_i,
   input  logic                  clear_i,
   input  logic                  snap_ack_i,
   input  logic [TW-1:0]         cfg_win_min_i,
   input  logic [TW-1:0]         cfg_win_max_i,
   input  logic [TW-1:0]         cfg_recover_i,
   input  logic [TW-1:0]         cfg_flush_i,
   input  logic [TW-1:0]         cfg_backoff_i,
   input  logic [TSW-1:0]        cfg_loop_win_i,
   output logic [NUM_STAGES-1:0] act_o,
   output logic                  snap_req_o,
   output logic                  safe_o,
   output logic [2:0]            cause_o,
   output logic [2:0]            stage_o,
   output logic [CW-1:0]         fail_cnt_o
);

   if (LOOP_N < 1) begin : g_bad_loop
      $error("rl_supervisor: LOOP_N must be at least 1");
   end

   logic    hb_fault;
   logic    mon_en;
   logic    hb_restart;
   logic    record;
   logic    guard_clear;
   logic    guard_full;
   logic    trig;
   cause_e  cause_sel;
   cause_e  cause_rec;
   stage_e  stage_rec;

   rl_hb_window #(
      .TW(TW)
   ) hb_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (mon_en),
      .restart_i (hb_restart),
      .kick_i    (hb_kick_i),
      .win_min_i (cfg_win_min_i),
      .win_max_i (cfg_win_max_i),
      .fault_o   (hb_fault)
   );

   always_comb begin
      trig      = hb_fault | stall_i | thermal_i | power_i | manual_i;
      cause_sel = pick_cause(manual_i, power_i, thermal_i, stall_i, hb_fault);
   end

   rl_loop_guard #(
      .SLOTS(LOOP_N),
      .TSW  (TSW),
      .CW   (CW)
   ) guard_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (guard_clear),
      .record_i (record),
      .win_i    (cfg_loop_win_i),
      .count_o  (fail_cnt_o),
      .full_o   (guard_full)
   );

   rl_ladder_fsm #(
      .TW(TW),
      .CW(CW)
   ) ladder_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .trig_i        (trig),
      .cause_i       (cause_sel),
      .guard_full_i  (guard_full),
      .fail_cnt_i    (fail_cnt_o),
      .snap_ack_i    (snap_ack_i),
      .clear_i       (clear_i),
      .cfg_recover_i (cfg_recover_i),
      .cfg_flush_i   (cfg_flush_i),
      .cfg_backoff_i (cfg_backoff_i),
      .act_o         (act_o),
      .snap_req_o    (snap_req_o),
      .safe_o        (safe_o),
      .mon_en_o      (mon_en),
      .hb_restart_o  (hb_restart),
      .record_o      (record),
      .guard_clear_o (guard_clear),
      .cause_o       (cause_rec),
      .stage_o       (stage_rec)
   );

   assign cause_o = cause_rec;
   assign stage_o = stage_rec;

   // a snapshot request always carries a real cause
   assert_cause_recorded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snap_req_o |-> (cause_o != 3'd0));

endmodule

// File: tb/rl_supervisor_tb_top.sv
`timescale 1ns/1ps
module rl_supervisor_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kick = 1'b0, stall = 1'b0, thermal = 1'b0, power = 1'b0, manual = 1'b0;
   logic        clear = 1'b0, ack = 1'b0;
   logic [15:0] win_min = 16'd8, win_max = 16'd20, recov = 16'd40, flush = 16'd5, backoff = 16'd3;
   logic [19:0] loop_win = 20'd400;
   logic [4:0]  act;
   logic        snap, safe;
   logic [2:0]  cause, stage;
   logic [1:0]  fail_cnt;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rl_supervisor dut_i (
      .clk_i(clk), .rst_ni(rst_n), .hb_kick_i(kick), .stall_i(stall),
      .thermal_i(thermal), .power_i(power), .manual_i(manual), .clear_i(clear),
      .snap_ack_i(ack), .cfg_win_min_i(win_min), .cfg_win_max_i(win_max),
      .cfg_recover_i(recov), .cfg_flush_i(flush), .cfg_backoff_i(backoff),
      .cfg_loop_win_i(loop_win), .act_o(act), .snap_req_o(snap), .safe_o(safe),
      .cause_o(cause), .stage_o(stage), .fail_cnt_o(fail_cnt)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic do_reset(input int mn, input int mx, input int rc, input int fl,
                           input int bo, input int lw);
      @(negedge clk);
      rst_n = 1'b0;
      {kick, stall, thermal, power, manual, clear, ack} = '0;
      win_min = 16'(mn); win_max = 16'(mx); recov = 16'(rc);
      flush = 16'(fl); backoff = 16'(bo); loop_win = 20'(lw);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse(input logic k, input logic s, input logic t, input logic p,
                        input logic m);
      @(negedge clk);
      {kick, stall, thermal, power, manual} = {k, s, t, p, m};
      @(negedge clk);
      {kick, stall, thermal, power, manual} = '0;
   endtask

   // wait for snapshot request, check record, acknowledge, check pulse timing
   task automatic serve(input int ecause, input int estage, input int edelay, input string req);
      int seen = 0;
      int k_hit = -1;
      for (int i = 0; i < 500; i++) begin
         if (snap) begin seen = 1; break; end
         @(negedge clk);
      end
      chk({req, " snapshot request"}, seen, 1);
      chk({req, " cause"}, int'(cause), ecause);
      chk({req, " stage"}, int'(stage), estage);
      ack = 1'b1;
      @(posedge clk);
      #1 ack = 1'b0;
      for (int k = 1; k < 300; k++) begin
         @(posedge clk);
         #1;
         if (act != '0) begin
            k_hit = k;
            chk({req, " pulse bit"}, int'(act), 1 << estage);
            break;
         end
      end
      chk({req, " pulse delay"}, k_hit, edelay);
      @(posedge clk);
      #1 chk({req, " single pulse"}, int'(act), 0);
   endtask

   task automatic t_reset_state();
      do_reset(8, 20, 40, 5, 3, 400);
      @(negedge clk);
      chk("R12 act", int'(act), 0);
      chk("R12 snap", int'(snap), 0);
      chk("R12 safe", int'(safe), 0);
      chk("R12 cause", int'(cause), 0);
      chk("R12 stage", int'(stage), 0);
      chk("R12 fail", int'(fail_cnt), 0);
   endtask

   task automatic t_good_kicks();
      int bad = 0;
      do_reset(8, 20, 40, 5, 3, 400);
      for (int n = 0; n < 8; n++) begin
         for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            if (snap) bad = 1;
         end
         pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      end
      chk("R2 valid kicks raise nothing", bad, 0);
   endtask

   task automatic t_early_kick();
      do_reset(8, 20, 40, 5, 3, 400);
      repeat (3) @(negedge clk);
      pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      serve(1, 0, 6, "R2 early kick");
      chk("R8 one action counted", int'(fail_cnt), 1);
   endtask

   task automatic t_late_kick();
      int n = 0;
      do_reset(8, 20, 40, 5, 3, 400);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         n++;
         if (snap) break;
      end
      chk("R2 late fault not before window end", int'(n >= 20), 1);
      chk("R2 late fault right after window end", int'(n <= 22), 1);
      chk("R2 late cause", int'(cause), 1);
   endtask

   task automatic t_priority();
      do_reset(8, 200, 40, 5, 3, 400);
      pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      serve(3, 0, 6, "R3 thermal over stall");
      do_reset(8, 200, 40, 5, 3, 400);
      pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      serve(4, 0, 6, "R3 power over thermal");
      do_reset(8, 200, 40, 5, 3, 400);
      pulse(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      serve(5, 0, 6, "R3 manual first");
      do_reset(8, 200, 40, 5, 3, 400);
      pulse(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      serve(2, 0, 6, "R3 stall over heartbeat");
   endtask

   task automatic t_snapshot_wait();
      int bad = 0;
      do_reset(8, 200, 40, 5, 3, 400);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (!snap || act != '0) bad = 1;
      end
      chk("R4 request held without pulse", bad, 0);
      serve(2, 0, 6, "R4 late ack");
   endtask

   task automatic t_ladder_to_safe();
      int bad = 0;
      do_reset(8, 20, 40, 5, 3, 10);
      serve(1, 0, 6, "R6 stage svc");
      serve(1, 1, 6, "R6 stage module");
      serve(1, 2, 6, "R6 stage warm");
      serve(1, 3, 6, "R6 stage cold");
      serve(1, 4, 6, "R6 safe entry");
      chk("R6 safe active", int'(safe), 1);
      pulse(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (snap || act != '0) bad = 1;
      end
      chk("R10 triggers ignored in safe", bad, 0);
      chk("R10 safe held", int'(safe), 1);
      @(negedge clk); clear = 1'b1;
      @(negedge clk); clear = 1'b0;
      chk("R11 safe left on clear", int'(safe), 0);
      chk("R11 window emptied", int'(fail_cnt), 0);
      pulse(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      serve(5, 0, 6, "R11 ladder restarts");
   endtask

   task automatic t_guard_backoff();
      do_reset(8, 200, 40, 5, 3, 2000);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      serve(2, 0, 6, "R5 no backoff");
      chk("R8 count one", int'(fail_cnt), 1);
      repeat (50) @(negedge clk);
      clear = 1'b1;
      @(negedge clk); clear = 1'b0;
      @(negedge clk);
      chk("R11 clear ignored outside safe count", int'(fail_cnt), 1);
      chk("R11 clear ignored outside safe mode", int'(safe), 0);
      chk("R11 clear ignored outside safe snap", int'(snap), 0);
      pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      serve(4, 0, 9, "R5 one backoff step");
      repeat (50) @(negedge clk);
      pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      serve(3, 0, 12, "R5 two backoff steps");
      chk("R8 count three", int'(fail_cnt), 3);
      repeat (50) @(negedge clk);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      serve(2, 4, 15, "R9 forced safe");
      chk("R9 safe active", int'(safe), 1);
   endtask

   task automatic t_escalate_and_recover();
      do_reset(8, 200, 40, 5, 3, 2000);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      serve(2, 0, 6, "R6 first action");
      pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      serve(3, 1, 9, "R6 escalate in recovery");
      repeat (60) @(negedge clk);
      pulse(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      serve(5, 0, 12, "R7 ladder back to stage 0");
      chk("R7 count kept", int'(fail_cnt), 3);
   endtask

   task automatic t_window_expiry();
      do_reset(8, 200, 40, 5, 3, 60);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      serve(2, 0, 6, "R8 action");
      repeat (45) @(negedge clk);
      chk("R8 inside window", int'(fail_cnt), 1);
      repeat (25) @(negedge clk);
      chk("R8 aged out", int'(fail_cnt), 0);
   endtask

   initial begin
      t_reset_state();
      t_good_kicks();
      t_early_kick();
      t_late_kick();
      t_priority();
      t_snapshot_wait();
      t_ladder_to_safe();
      t_guard_backoff();
      t_escalate_and_recover();
      t_window_expiry();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule